// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block sits between a processor's load/store port and memory. It is a direct-mapped cache of one-word lines with a write-through, no-write-allocate policy. Each line holds a valid bit, a tag and one data word. A store is finished, from the processor's side, in the cycle its address and data enter a four-entry FIFO store queue. The queue then drains to memory in the background, one entry per write handshake, and only the written word is sent. A store that hits the cache also updates the cached word. A store that misses leaves the cache unchanged.

A load that hits returns the cached word in the same cycle. A load that misses asks memory for the word and installs it in the cache when the read is acknowledged. The miss waits, without reading memory, while any queued store targets the same address. Once that store has drained, the read returns the newly stored value. The processor presents one request at a time and holds it stable until `cpu_ready` is high. Addresses are word addresses. The line index is the low `IDX_W` address bits and the tag is the remaining upper bits.

Top module: `wt_store_cache`

## Requirements
- R1: After reset no line is valid, the store queue is empty, and `mem_wr_valid`, `mem_rd_req` and `cpu_ready` are low while no request is presented.
- R2: A load whose line is valid with a matching tag has `cpu_ready` high and the cached word on `cpu_rdata` in the same cycle, and `mem_rd_req` stays low.
- R3: A load that misses and has no queued store to its address drives `mem_rd_req` high with `mem_rd_addr` equal to the load address. In the cycle `mem_rd_ack` is high, `cpu_ready` is high, `cpu_rdata` equals `mem_rd_data`, and the word is installed so a later load to that address hits.
- R4: A store presented while the queue holds fewer than 4 entries is accepted (`cpu_ready` high) in that same cycle, whatever the state of the memory handshakes.
- R5: A store that hits replaces the cached word, so a later load to that address hits and returns the new data without a memory read.
- R6: A store that misses does not install a line, so a later load to that address misses and reads memory.
- R7: While the queue is not empty, `mem_wr_valid` is high with the oldest entry on `mem_wr_addr`/`mem_wr_data`. That entry is removed in a cycle where `mem_wr_ready` is high, exactly one entry per handshake, and the outputs are held while `mem_wr_ready` is low.
- R8: Queued stores reach memory in the order the processor issued them.
- R9: While 4 entries are queued, a store is not accepted. It is accepted in the cycle after a write handshake frees an entry.
- R10: A load miss whose address matches any queued entry keeps `mem_rd_req` low until that entry has drained. It then reads memory and returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` on a load |
| mem_wr_valid | output | 1 | Oldest queued store offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered store this cycle |
| mem_wr_addr | output | ADDR_W | Address of the offered store |
| mem_wr_data | output | DATA_W | Data of the offered store |
| mem_rd_req | output | 1 | Miss read request |
| mem_rd_ack | input | 1 | Memory returns read data this cycle |
| mem_rd_addr | output | ADDR_W | Miss read address |
| mem_rd_data | input | DATA_W | Read data, valid with `mem_rd_ack` |

## Verification
Every processor-facing result is combinational on the current request and registered state. So `cpu_ready`, `cpu_rdata`, `mem_rd_req` and the offered queue head are due in the very cycle the stimulus is presented. Line installs, line updates and queue pushes and pops become visible one clock later. The bench drives inputs just after a rising edge, compares all outputs against its behavioural model at the falling edge of that same cycle, and only then advances the model to the state it expects after the next rising edge. Directed sequences use cycle counts of waiting to tell a hit (zero waits) from a miss or a stall.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  // Line index: the low iw bits of a word address.
  function automatic logic [31:0] wtc_index(input logic [31:0] a, input int unsigned iw);
    return a & ((32'd1 << iw) - 32'd1);
  endfunction

  // Tag: everything above the index.
  function automatic logic [31:0] wtc_tag(input logic [31:0] a, input int unsigned iw);
    return a >> iw;
  endfunction

  // Circular pointer advance for a queue of the given depth.
  function automatic logic [31:0] wtc_wrap_inc(input logic [31:0] p, input int unsigned depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [AW-IW-1:0] rd_tag,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-IW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data
);
  localparam int LINES = 1 << IW;
  localparam int TW    = AW - IW;

  logic [LINES-1:0] line_vld;
  logic [TW-1:0]    line_tag [LINES];
  logic [DW-1:0]    line_dat [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line_vld <= '0;
    else if (wr_en) line_vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_tag[wr_idx] <= wr_tag;
      line_dat[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = line_vld[rd_idx];
  assign rd_tag   = line_tag[rd_idx];
  assign rd_data  = line_dat[rd_idx];
endmodule

// File: rtl/wtc_store_queue.sv
module wtc_store_queue
  import wtc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          not_empty,
  output logic          full,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    slot_addr [DEPTH];
  logic [DW-1:0]    slot_data [DEPTH];
  logic [DEPTH-1:0] slot_occ;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    fill_cnt;
  logic [DEPTH-1:0] slot_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      fill_cnt <= '0;
      slot_occ <= '0;
    end else begin
      if (push) begin
        wr_ptr           <= PW'(wtc_wrap_inc(32'(wr_ptr), DEPTH));
        slot_occ[wr_ptr] <= 1'b1;
      end
      if (pop) begin
        rd_ptr           <= PW'(wtc_wrap_inc(32'(rd_ptr), DEPTH));
        slot_occ[rd_ptr] <= 1'b0;
      end
      if (push && !pop)      fill_cnt <= fill_cnt + 1'b1;
      else if (pop && !push) fill_cnt <= fill_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[wr_ptr] <= push_addr;
      slot_data[wr_ptr] <= push_data;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_probe
    assign slot_match[s] = slot_occ[s] && (slot_addr[s] == probe_addr);
  end

  assign probe_hit = |slot_match;
  assign not_empty = (fill_cnt != '0);
  assign full      = (fill_cnt == CW'(DEPTH));
  assign head_addr = slot_addr[rd_ptr];
  assign head_data = slot_data[rd_ptr];
endmodule

// File: rtl/wt_store_cache.sv
module wt_store_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_rd_req,
  input  logic              mem_rd_ack,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  // Address split
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_idx = IDX_W'(wtc_index(32'(cpu_addr), IDX_W));
  assign req_tag = TAG_W'(wtc_tag(32'(cpu_addr), IDX_W));

  // Line storage
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              line_we;
  logic [DATA_W-1:0] line_wdata;

  // Store queue
  logic              wb_not_empty, wb_full, wb_hazard, wb_pop;
  logic [ADDR_W-1:0] wb_head_addr;
  logic [DATA_W-1:0] wb_head_data;

  // Named internal events, visible to the checker
  logic load_req, store_req, lookup_hit;
  logic store_accept, load_hit_ev, miss_issue, fill_ev;

  assign load_req     = cpu_valid && !cpu_we;
  assign store_req    = cpu_valid &&  cpu_we;
  assign lookup_hit   = line_valid && (line_tag == req_tag);
  assign store_accept = store_req && !wb_full;
  assign load_hit_ev  = load_req && lookup_hit;
  assign miss_issue   = load_req && !lookup_hit && !wb_hazard;
  assign fill_ev      = miss_issue && mem_rd_ack;
  assign wb_pop       = wb_not_empty && mem_wr_ready;

  // Write hit refreshes the word; a read fill installs the line.
  assign line_we    = fill_ev || (store_accept && lookup_hit);
  assign line_wdata = fill_ev ? mem_rd_data : cpu_wdata;

  wtc_line_store #(
    .AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)
  ) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_idx),
    .rd_valid(line_valid),
    .rd_tag  (line_tag),
    .rd_data (line_data),
    .wr_en   (line_we),
    .wr_idx  (req_idx),
    .wr_tag  (req_tag),
    .wr_data (line_wdata)
  );

  wtc_store_queue #(
    .AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (store_accept),
    .push_addr (cpu_addr),
    .push_data (cpu_wdata),
    .pop       (wb_pop),
    .not_empty (wb_not_empty),
    .full      (wb_full),
    .head_addr (wb_head_addr),
    .head_data (wb_head_data),
    .probe_addr(cpu_addr),
    .probe_hit (wb_hazard)
  );

  assign cpu_ready    = store_accept || load_hit_ev || fill_ev;
  assign cpu_rdata    = fill_ev ? mem_rd_data : line_data;
  assign mem_rd_req   = miss_issue;
  assign mem_rd_addr  = cpu_addr;
  assign mem_wr_valid = wb_not_empty;
  assign mem_wr_addr  = wb_head_addr;
  assign mem_wr_data  = wb_head_data;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [AW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic          mem_rd_req,
  input logic          mem_rd_ack,
  input logic [AW-1:0] mem_rd_addr,
  input logic          wb_full,
  input logic          store_accept,
  input logic          load_hit_ev,
  input logic          fill_ev
);
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit_ev |-> !mem_rd_req); // R2

  AST_LOAD_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && cpu_ready && !load_hit_ev) |-> (mem_rd_req && mem_rd_ack)); // R3

  AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_accept, load_hit_ev, fill_ev})); // R4

  AST_STORE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we && !wb_full) |-> cpu_ready); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we && wb_full) |-> !cpu_ready); // R9

  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_wr_valid) |-> (mem_wr_addr != mem_rd_addr)); // R10
endmodule

bind wt_store_cache wtc_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_valid   (cpu_valid),
  .cpu_we      (cpu_we),
  .cpu_ready   (cpu_ready),
  .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_ack  (mem_rd_ack),
  .mem_rd_addr (mem_rd_addr),
  .wb_full     (wb_full),
  .store_accept(store_accept),
  .load_hit_ev (load_hit_ev),
  .fill_ev     (fill_ev)
);

// File: tb/wt_store_cache_bench.sv
module wt_store_cache_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int QD = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_valid, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          mem_wr_valid, mem_wr_ready;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_rd_req, mem_rd_ack;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;

  always #5 clk = ~clk;

  wt_store_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .WB_DEPTH(QD)) u_wt_store_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  int vectors = 0;
  int miscompares = 0;

  function automatic logic [31:0] seed_word(input int a);
    return 32'(a) * 32'h9E3779B1 + 32'h55;
  endfunction

  // Bench memory (addresses kept below 256)
  logic [DW-1:0] mem_img [0:255];
  assign mem_rd_data = mem_img[mem_rd_addr[7:0]];
  always @(posedge clk)
    if (mem_wr_valid && mem_wr_ready) mem_img[mem_wr_addr[7:0]] <= mem_wr_data;

  // Memory handshake patterns: 0 low, 1 high, 2 pseudo-random
  int wr_mode = 1;
  int rd_mode = 1;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wr_ready = (wr_mode == 2) ? lfsr[0] : (wr_mode == 1);
    mem_rd_ack   = (rd_mode == 2) ? lfsr[3] : (rd_mode == 1);
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } sq_t;
  sq_t q[$];
  logic [DW-1:0] rmem [0:255];
  bit            cv [16];
  logic [11:0]   ct [16];
  logic [DW-1:0] cd [16];

  bit m_ld, m_st, m_hit, m_full, m_conf, m_rdreq, m_ready;
  logic [DW-1:0] m_rdata;
  int m_idx;
  string lbl;

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      foreach (cv[i]) cv[i] = 1'b0;
    end else begin
      m_ld   = cpu_valid && !cpu_we;
      m_st   = cpu_valid && cpu_we;
      m_idx  = int'(cpu_addr[3:0]);
      m_hit  = cv[m_idx] && (ct[m_idx] == cpu_addr[15:4]);
      m_full = (q.size() == QD);
      m_conf = 1'b0;
      foreach (q[i]) if (q[i].a == cpu_addr) m_conf = 1'b1;
      m_rdreq = m_ld && !m_hit && !m_conf;
      m_ready = (m_st && !m_full) || (m_ld && m_hit) || (m_rdreq && mem_rd_ack);
      m_rdata = m_hit ? cd[m_idx] : rmem[cpu_addr[7:0]];

      if (m_st)      lbl = m_full ? "R9" : "R4";
      else if (m_ld) lbl = m_hit ? "R2" : (m_conf ? "R10" : "R3");
      else           lbl = "R1";
      chk(lbl, "cpu_ready", 64'(cpu_ready), 64'(m_ready));
      chk(m_conf ? "R10" : "R3", "mem_rd_req", 64'(mem_rd_req), 64'(m_rdreq));
      if (m_rdreq) chk("R3", "mem_rd_addr", 64'(mem_rd_addr), 64'(cpu_addr));
      if (m_ld && m_ready) chk(m_hit ? "R2" : "R3", "cpu_rdata", 64'(cpu_rdata), 64'(m_rdata));
      chk("R7", "mem_wr_valid", 64'(mem_wr_valid), 64'(q.size() > 0));
      if (q.size() > 0) begin
        chk("R8", "mem_wr_addr", 64'(mem_wr_addr), 64'(q[0].a));
        chk("R8", "mem_wr_data", 64'(mem_wr_data), 64'(q[0].d));
      end

      // advance to the state after the coming rising edge
      if (m_rdreq && mem_rd_ack) begin
        cv[m_idx] = 1'b1; ct[m_idx] = cpu_addr[15:4]; cd[m_idx] = rmem[cpu_addr[7:0]];
      end
      if (q.size() > 0 && mem_wr_ready) begin
        rmem[q[0].a[7:0]] = q[0].d;
        void'(q.pop_front());
      end
      if (m_st && !m_full) begin
        if (m_hit) cd[m_idx] = cpu_wdata;
        q.push_back('{a: cpu_addr, d: cpu_wdata});
      end
    end
  end

  // ---------------- processor driver ----------------
  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int waited, output logic [DW-1:0] got);
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waited = 0;
    forever begin
      @(negedge clk);
      if (cpu_ready) break;
      waited++;
    end
    got = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int w;
    logic [DW-1:0] g;
    for (int a = 0; a < 256; a++) begin
      mem_img[a] = seed_word(a);
      rmem[a]    = seed_word(a);
    end
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_wr_ready = 1'b1; mem_rd_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "mem_wr_valid in reset", 64'(mem_wr_valid), 64'd0);
    chk("R1", "mem_rd_req in reset", 64'(mem_rd_req), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cpu_ready idle", 64'(cpu_ready), 64'd0);

    // R3: cold miss fills; R2: second load hits with memory read held off
    do_req(1'b0, 16'h0013, '0, w, g);
    chk("R3", "miss data", 64'(g), 64'(seed_word(16'h13)));
    rd_mode = 0; wr_mode = 0;
    do_req(1'b0, 16'h0013, '0, w, g);
    chk("R2", "hit wait cycles", 64'(w), 64'd0);
    chk("R2", "hit data", 64'(g), 64'(seed_word(16'h13)));

    // R5: store hit, then load returns new word without memory
    do_req(1'b1, 16'h0013, 32'hDEAD0001, w, g);
    chk("R4", "store accept waits", 64'(w), 64'd0);
    do_req(1'b0, 16'h0013, '0, w, g);
    chk("R5", "load after store hit waits", 64'(w), 64'd0);
    chk("R5", "load after store hit data", 64'(g), 64'hDEAD0001);

    // R10: load miss behind a queued store to the same address
    do_req(1'b1, 16'h0025, 32'hBEEF0002, w, g);
    rd_mode = 1;
    fork
      do_req(1'b0, 16'h0025, '0, w, g);
      begin repeat (6) @(posedge clk); wr_mode = 1; end
    join
    chk("R10", "hazard wait at least 5", 64'(w >= 5), 64'd1);
    chk("R10", "data after drain", 64'(g), 64'hBEEF0002);

    // R6: store miss does not allocate
    do_req(1'b1, 16'h0047, 32'hC0DE0003, w, g);
    repeat (3) @(posedge clk);
    rd_mode = 0;
    fork
      do_req(1'b0, 16'h0047, '0, w, g);
      begin repeat (4) @(posedge clk); rd_mode = 1; end
    join
    chk("R6", "store miss then load waits", 64'(w >= 3), 64'd1);
    chk("R6", "store miss then load data", 64'(g), 64'hC0DE0003);

    // R9: fill the queue, fifth store stalls until a drain
    wr_mode = 0;
    for (int k = 0; k < 4; k++) begin
      do_req(1'b1, AW'(16'h0030 + k), 32'h5000_0000 + 32'(k), w, g);
      chk("R4", "store with room waits", 64'(w), 64'd0);
    end
    fork
      do_req(1'b1, 16'h0034, 32'h5000_0004, w, g);
      begin repeat (5) @(posedge clk); wr_mode = 1; end
    join
    chk("R9", "full stall waits", 64'(w >= 4), 64'd1);
    repeat (10) @(posedge clk);
    // R8: drained in order, read back through misses
    for (int k = 0; k < 5; k++) begin
      do_req(1'b0, AW'(16'h0030 + k), '0, w, g);
      chk("R8", "ordered drain data", 64'(g), 64'(32'h5000_0000 + 32'(k)));
    end

    // Mixed traffic with random handshakes
    wr_mode = 2; rd_mode = 2;
    for (int n = 0; n < 400; n++) begin
      do_req(1'($urandom_range(0, 1)), AW'($urandom_range(0, 255)), $urandom, w, g);
    end
    wr_mode = 1;
    repeat (20) @(posedge clk);
    summary();
    $finish;
  end
endmodule